// File: doc/BRIEF.md
# Six-Tap Half-Sample Interpolator

This block is a streaming one-dimensional interpolation filter for sub-sample motion search in a video encoder. Unsigned 8-bit samples of one row arrive one per handshake. Each output is an estimate of the value midway between the two middle samples of the six most recent inputs.

The six samples form three mirror-image pairs. The two middle samples get weight 20, the pair just outside them gets weight -5, and the two end samples get weight 1. Each pair is summed first. That sum is then scaled with shifts and adds only (20 = 16 + 4, 5 = 4 + 1), and the result joins one signed accumulator. The accumulator is rounded, scaled down by 32 and saturated to the 8-bit sample range.

The input stream and the output stream both use valid/ready handshakes. One output register sits between them. A new sample is taken whenever that register is empty or is being drained in the same cycle. While the consumer holds back, the output keeps its value and the input is not ready, so no sample is ever dropped. After reset the first five samples only fill the window. From the sixth on, every accepted sample yields exactly one output, in input order, one cycle later.

Top module: `halfpel_fir6`

## Requirements
- R1: With the window s0 (oldest, accepted first) through s5 (newest, accepted last), the pre-rounding sum is acc = (s0+s5) - 5*(s1+s4) + 20*(s2+s3), formed in a signed accumulator wide enough that no window overflows.
- R2: The sum is rounded by adding 16 and shifting right by 5 with an arithmetic (floor) shift. For example, a window with s0=16 and all other samples 0 gives 1, and s0=15 with all other samples 0 gives 0.
- R3: A shifted result below 0 is output as 0, and a result above 255 is output as 255.
- R4: After reset, out_valid stays low until six samples have been accepted. From then on, each accepted sample yields one output with out_valid high at the next clock edge, and outputs keep input order.
- R5: While out_valid is high and out_ready is low, out_data and out_valid hold their values and in_ready is low.
- R6: in_ready is high whenever out_valid is low or out_ready is high. A transfer on the output with no sample accepted in the same cycle leaves out_valid low in the next cycle.
- R7: An asynchronous active-low reset clears out_valid and empties the window, so another six samples are needed before the next output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_data | input | 8 | Unsigned input sample |
| out_valid | output | 1 | Interpolated sample available |
| out_ready | input | 1 | Consumer takes the output this cycle |
| out_data | output | 8 | Interpolated, saturated sample |

## Verification
The filter is tried with several fixed windows, each with a hand-derived result:
- All-zero and all-255 windows pin the two ends of the range.
- Two opposite alternating 0/255 phases give equal pair sums, so a swapped coefficient shows up.
- Impulses at the middle, inner and end positions each isolate one weight.
- A window whose inner pair is large drives the result below zero, and one whose middle and end pairs are large drives it above 255. These two exercise the saturation.
- The s0=15 and s0=16 end impulses sit on the two sides of the rounding step.
- A rising ramp checks the order of the taps.

After these fixed windows, a long random stream with random gaps on both handshakes is compared sample by sample with a model, which checks ordering and back-pressure. Directed tests cover the fill after reset and a held output.

// File: rtl/hpf_pkg.sv
package hpf_pkg;
  // Number of samples in the filter window and of symmetric pairs
  localparam int unsigned HPF_TAPS  = 6;
  localparam int unsigned HPF_PAIRS = HPF_TAPS / 2;

  // Pair k is (k, TAPS-1-k); k=0 is the outer pair, k=2 the centre pair.
  // Weight = (pair << hi) + (two ? pair << lo : 0), negated when sub is set.
  function automatic int unsigned step_sh_hi(int unsigned k);
    case (k)
      0:       return 0;  // weight 1
      1:       return 2;  // 4 of weight 5
      default: return 4;  // 16 of weight 20
    endcase
  endfunction

  function automatic int unsigned step_sh_lo(int unsigned k);
    case (k)
      0:       return 0;
      1:       return 0;  // 1 of weight 5
      default: return 2;  // 4 of weight 20
    endcase
  endfunction

  function automatic bit step_two(int unsigned k);
    return k != 0;
  endfunction

  function automatic bit step_sub(int unsigned k);
    return k == 1;
  endfunction
endpackage

// File: rtl/hpf_window.sv
module hpf_window #(
  parameter int unsigned SAMPLE_W = 8,
  parameter int unsigned TAPS     = 6
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           push,
  input  logic [SAMPLE_W-1:0]            din,
  output logic [TAPS-1:0][SAMPLE_W-1:0]  win_nxt,
  output logic                           last_fill
);
  localparam int unsigned CNT_W = $clog2(TAPS);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(TAPS - 1);

  logic [TAPS-1:0][SAMPLE_W-1:0] taps_q;
  logic [CNT_W-1:0]              fill_q;

  // Index 0 holds the oldest sample, TAPS-1 the newest.
  for (genvar i = 0; i < TAPS - 1; i++) begin : g_shift
    assign win_nxt[i] = taps_q[i+1];
  end
  assign win_nxt[TAPS-1] = din;

  // High when the sample being pushed completes a full window
  assign last_fill = (fill_q == CNT_TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taps_q <= '0;
      fill_q <= '0;
    end else if (push) begin
      taps_q <= win_nxt;
      if (fill_q != CNT_TOP) fill_q <= fill_q + 1'b1;
    end
  end
endmodule

// File: rtl/hpf_pair_step.sv
module hpf_pair_step #(
  parameter int unsigned SAMPLE_W = 8,
  parameter int unsigned ACC_W    = 16,
  parameter int unsigned SH_HI    = 0,
  parameter int unsigned SH_LO    = 0,
  parameter bit          TWO      = 1'b0,
  parameter bit          SUB      = 1'b0
) (
  input  logic [SAMPLE_W-1:0]      a,
  input  logic [SAMPLE_W-1:0]      b,
  input  logic signed [ACC_W-1:0]  acc_in,
  output logic signed [ACC_W-1:0]  acc_out
);
  logic signed [ACC_W-1:0] pair_s;
  logic signed [ACC_W-1:0] term;

  assign pair_s = $signed({{(ACC_W-SAMPLE_W){1'b0}}, a})
                + $signed({{(ACC_W-SAMPLE_W){1'b0}}, b});

  if (TWO) begin : g_two
    assign term = (pair_s <<< SH_HI) + (pair_s <<< SH_LO);
  end else begin : g_one
    assign term = pair_s <<< SH_HI;
  end

  if (SUB) begin : g_sub
    assign acc_out = acc_in - term;
  end else begin : g_add
    assign acc_out = acc_in + term;
  end
endmodule

// File: rtl/hpf_round_clamp.sv
module hpf_round_clamp #(
  parameter int unsigned ACC_W = 16,
  parameter int unsigned OUT_W = 8,
  parameter int unsigned SH    = 5
) (
  input  logic signed [ACC_W-1:0] acc,
  output logic [OUT_W-1:0]        q
);
  localparam logic signed [ACC_W-1:0] RND  = ACC_W'(1) <<< (SH - 1);
  localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((1 << OUT_W) - 1);

  logic signed [ACC_W-1:0] scaled;

  assign scaled = (acc + RND) >>> SH;

  always_comb begin
    if (scaled < 0)         q = '0;
    else if (scaled > MAXV) q = '1;
    else                    q = scaled[OUT_W-1:0];
  end
endmodule

// File: rtl/halfpel_fir6.sv
module halfpel_fir6 #(
  parameter int unsigned SAMPLE_W = 8,
  parameter int unsigned SCALE_SH = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] in_data,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [SAMPLE_W-1:0] out_data
);
  import hpf_pkg::*;

  // 20*2*max sample needs SAMPLE_W+6 bits plus sign; one spare bit
  localparam int unsigned ACC_W = SAMPLE_W + 8;
  localparam int unsigned TAPS  = HPF_TAPS;
  localparam int unsigned PAIRS = HPF_PAIRS;

  logic                          accept;
  logic                          last_fill;
  logic [TAPS-1:0][SAMPLE_W-1:0] win_nxt;
  logic signed [ACC_W-1:0]       chain [0:PAIRS];
  logic [SAMPLE_W-1:0]           filt_q;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  hpf_window #(.SAMPLE_W(SAMPLE_W), .TAPS(TAPS)) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (accept),
    .din      (in_data),
    .win_nxt  (win_nxt),
    .last_fill(last_fill)
  );

  // Outer pair first, centre pair last, all into one accumulator chain
  assign chain[0] = '0;
  for (genvar k = 0; k < PAIRS; k++) begin : g_step
    hpf_pair_step #(
      .SAMPLE_W(SAMPLE_W),
      .ACC_W   (ACC_W),
      .SH_HI   (step_sh_hi(k)),
      .SH_LO   (step_sh_lo(k)),
      .TWO     (step_two(k)),
      .SUB     (step_sub(k))
    ) u_step (
      .a      (win_nxt[k]),
      .b      (win_nxt[TAPS-1-k]),
      .acc_in (chain[k]),
      .acc_out(chain[k+1])
    );
  end

  hpf_round_clamp #(.ACC_W(ACC_W), .OUT_W(SAMPLE_W), .SH(SCALE_SH)) u_sat (
    .acc(chain[PAIRS]),
    .q  (filt_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (accept && last_fill) begin
      out_valid <= 1'b1;
      out_data  <= filt_q;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/halfpel_fir6_chk.sv
module halfpel_fir6_chk #(
  parameter int unsigned SAMPLE_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic                out_valid,
  input logic                out_ready,
  input logic [SAMPLE_W-1:0] out_data
);
  logic [2:0] seen_q;
  logic       took;

  assign took = in_valid && in_ready;

  // Independent count of accepted samples, saturating at six
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    seen_q <= '0;
    else if (took && seen_q != 3'd6) seen_q <= seen_q + 3'd1;
  end

  AST_FILL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (seen_q == 3'd6)); // R4
  AST_EMIT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (took && seen_q >= 3'd5) |=> out_valid); // R4
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R5
  AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R5
  AST_DRAIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ready && !took) |=> !out_valid); // R6
  AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q == 3'd0) |-> !out_valid); // R7
endmodule

bind halfpel_fir6 halfpel_fir6_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_data (out_data)
);

// File: tb/halfpel_fir6_tb.sv
module halfpel_fir6_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_data;

  int n_chk = 0;
  int n_bad = 0;
  int n_in  = 0;
  int n_out = 0;
  int hist [0:4095];
  int outs [0:4095];
  bit rand_ready = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  halfpel_fir6 u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  // Six samples (oldest first) and the expected result
  localparam logic [7:0] VEC [0:10][0:6] = '{
    '{8'd0,   8'd0,   8'd0,   8'd0,   8'd0,   8'd0,   8'd0},    // zeros
    '{8'd255, 8'd255, 8'd255, 8'd255, 8'd255, 8'd255, 8'd255},  // all max
    '{8'd0,   8'd255, 8'd0,   8'd255, 8'd0,   8'd255, 8'd128},  // alternate A
    '{8'd255, 8'd0,   8'd255, 8'd0,   8'd255, 8'd0,   8'd128},  // alternate B
    '{8'd0,   8'd255, 8'd0,   8'd0,   8'd255, 8'd0,   8'd0},    // negative clamp
    '{8'd255, 8'd0,   8'd255, 8'd255, 8'd0,   8'd255, 8'd255},  // high clamp
    '{8'd10,  8'd20,  8'd30,  8'd40,  8'd50,  8'd60,  8'd35},   // ramp
    '{8'd0,   8'd0,   8'd100, 8'd0,   8'd0,   8'd0,   8'd63},   // centre impulse
    '{8'd0,   8'd100, 8'd0,   8'd0,   8'd0,   8'd0,   8'd0},    // inner impulse
    '{8'd16,  8'd0,   8'd0,   8'd0,   8'd0,   8'd0,   8'd1},    // round up edge
    '{8'd15,  8'd0,   8'd0,   8'd0,   8'd0,   8'd0,   8'd0}     // round down edge
  };

  function automatic int model(int s0, int s1, int s2, int s3, int s4, int s5);
    int acc;
    int r;
    acc = (s0 + s5) - 5 * (s1 + s4) + 20 * (s2 + s3);
    r = (acc + 16) >>> 5;
    if (r < 0) r = 0;
    if (r > 255) r = 255;
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor away from the active edge: records transfers due at the next edge
  always @(negedge clk) begin
    if (!rst_n) begin
      n_in  = 0;
      n_out = 0;
    end else begin
      if (out_valid && out_ready) begin
        // R1 R2 R3 R4: each output matches the model of its own window, in order
        chk(n_out + 5 < n_in,
            "R4 output without full window", n_out, n_in);
        if (n_out + 5 < n_in)
          chk(out_data == model(hist[n_out], hist[n_out+1], hist[n_out+2],
                                hist[n_out+3], hist[n_out+4], hist[n_out+5]),
              "R1 stream vs model", out_data,
              model(hist[n_out], hist[n_out+1], hist[n_out+2],
                    hist[n_out+3], hist[n_out+4], hist[n_out+5]));
        outs[n_out] = out_data;
        n_out++;
      end
      if (in_valid && in_ready) begin
        hist[n_in] = in_data;
        n_in++;
      end
    end
  end

  always @(posedge clk) begin
    if (rand_ready) begin
      #1 out_ready = ($urandom_range(0, 3) != 0);
    end
  end

  task automatic push(input logic [7:0] s);
    in_valid = 1'b1;
    in_data  = s;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] held;
    // R7: reset state
    idle(3);
    @(negedge clk);
    chk(out_valid == 1'b0, "R7 reset out_valid", out_valid, 0);
    chk(in_ready == 1'b1, "R6 reset in_ready", in_ready, 1);
    @(posedge clk);
    #1 rst_n = 1'b1;
    idle(2);

    // Table walk: consecutive windows streamed back to back
    for (int v = 0; v < 11; v++)
      for (int j = 0; j < 6; j++) push(VEC[v][j]);
    idle(4);
    chk(n_out == 61, "R4 one output per input after fill", n_out, 61);
    for (int v = 0; v < 11; v++)
      chk(outs[6*v] == VEC[v][6], "R1 R2 R3 table window", outs[6*v], VEC[v][6]);

    // R5: hold under back-pressure
    out_ready = 1'b0;
    push(8'd200);
    @(negedge clk);
    held = out_data;
    chk(out_valid == 1'b1, "R5 output offered", out_valid, 1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(out_valid == 1'b1 && out_data == held, "R5 stall hold", out_data, held);
      chk(in_ready == 1'b0, "R5 stall in_ready", in_ready, 0);
    end
    @(posedge clk);
    #1 out_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R6 drain clears out_valid", out_valid, 0);
    chk(in_ready == 1'b1, "R6 ready when empty", in_ready, 1);

    // Random stream with random gaps on both sides, checked by the monitor
    rand_ready = 1'b1;
    for (int i = 0; i < 600; i++) begin
      if (i % 40 == 0)      push(8'd0);
      else if (i % 40 == 1) push(8'd255);
      else                  push(8'($urandom_range(0, 255)));
      if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
    end
    rand_ready = 1'b0;
    @(posedge clk);
    #1 out_ready = 1'b1;
    idle(4);
    chk(n_out == n_in - 5, "R4 random stream count", n_out, n_in - 5);

    // R7 R4: reset empties the window, next output only after six samples
    rst_n = 1'b0;
    idle(2);
    @(negedge clk);
    chk(out_valid == 1'b0, "R7 out_valid in reset", out_valid, 0);
    @(posedge clk);
    #1 rst_n = 1'b1;
    for (int j = 0; j < 5; j++) begin
      push(8'd90);
      @(negedge clk);
      chk(out_valid == 1'b0, "R4 R7 no output while filling", out_valid, 0);
      @(posedge clk);
      #1;
    end
    out_ready = 1'b0;
    push(8'd90);
    @(negedge clk);
    // flat window of 90: 90*32 = 2880, (2880+16)>>5 = 90
    chk(out_valid == 1'b1, "R4 output after sixth sample", out_valid, 1);
    chk(out_data == 8'd90, "R1 flat window", out_data, 90);
    @(posedge clk);
    #1 out_ready = 1'b1;
    idle(3);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule